// File: doc/BRIEF.md
# Cascaded Three-Word Event Pending Controller

The controller gathers up to 96 single-cycle event notifications into three 32-bit pending words. A producer presents an event number on the set stream; the upper two bits of the 7-bit number pick the word and the lower five pick the bit. A separate clear stream removes a single pending bit by number. Software reads the words over a simple register bus. Writing ones to a pending word acknowledges those events.

The two highest bits of word 0 are summary flags, and the controller maintains them itself. Bit 30 is high exactly while word 1 holds any pending bit. Bit 31 is high exactly while word 2 holds any pending bit. Software therefore needs to read only word 0 to learn whether the upper words need attention, and it can never clear these flags directly.

Three interrupt levels each own a mask word per pending word. An interrupt line is a level: it is high while any pending bit, summary flags included, meets a set bit in that level's mask for the same word.

Top module: `evt_pend_ctrl`

## Requirements
- R1: A set beat with number N (bits 6:5 = word, bits 4:0 = bit) makes that bit read as 1 at byte address 4*word from the clock edge that accepts the beat.
- R2: From that same edge, accepting a number from 32 to 63 makes word 0 bit 30 read as 1, and accepting a number from 64 to 95 makes word 0 bit 31 read as 1.
- R3: A clear beat removes only its own bit. Word 0 bit 30 (or bit 31) drops on the same edge that leaves word 1 (or word 2) empty, and stays up while the word still holds other bits.
- R4: A bus write to address 0x00 clears every bit of word 0 written as 1, except bits 31:30, which are left unchanged.
- R5: Bus writes to address 0x04 leave word 1 unchanged.
- R6: A bus write to address 0x08 clears every bit of word 2 written as 1. If word 2 becomes empty, word 0 bit 31 drops on the same edge.
- R7: The mask word for level L (0..2) and pending word K (0..2) is a read/write register at byte address 0x10*(L+1) + 4*K. irq[L] is high whenever, for some K, pending word K AND that mask word is nonzero. irq[L] follows the registers in the same cycle.
- R8: When a set beat and a clear beat name the same bit in one cycle, the bit ends up set.
- R9: Set and clear beats with numbers 96 to 127 change nothing.
- R10: After reset, every pending and mask register reads 0 and all irq lines are low. Unmapped addresses read 0, and writes to them change nothing.
- R11: Both event streams are always ready outside reset. Each stream accepts at most one beat per cycle and never applies back-pressure. During reset, both ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_valid | input | 1 | Set stream: beat present |
| evt_set_ready | output | 1 | Set stream: accept (high outside reset) |
| evt_set_idx | input | 7 | Set stream: event number |
| evt_clr_valid | input | 1 | Clear stream: beat present |
| evt_clr_ready | output | 1 | Clear stream: accept (high outside reset) |
| evt_clr_idx | input | 7 | Clear stream: event number |
| reg_wr_en | input | 1 | Register bus write strobe |
| reg_addr | input | 8 | Register byte address (bits 1:0 ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 3 | Level interrupt per priority level |

## Verification
The assertions rely on three properties of the inputs: each stream presents at most one beat per clock, a bus write and a mask write never happen in the same cycle because they share one strobe, and beats count only after reset is released. The bench drives every stimulus from one sequential task, one beat per stream per cycle. That stimulus deliberately includes event numbers above 95, set and clear beats that collide on the same bit, and writes to unmapped addresses, so the assertions guarding those cases are actually exercised and not left idle.

// File: rtl/evp_pkg.sv
package evp_pkg;

  // How a pending word treats a bus write.
  typedef enum logic [0:0] {
    WR_CLEARS  = 1'b0,   // write-one-to-clear
    WR_IGNORED = 1'b1    // read-only to the bus
  } wr_policy_e;

  // Register bus layout: 16-byte groups, one 32-bit word per slot.
  localparam int GRP_LSB   = 4;
  localparam int SLOT_LSB  = 2;
  localparam int SLOT_W    = GRP_LSB - SLOT_LSB;
  localparam int GRP_PEND  = 0;

endpackage

// File: rtl/evp_pend_word.sv
module evp_pend_word
  import evp_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter int                BIT_W     = 5,
  parameter wr_policy_e        POLICY    = WR_CLEARS,
  parameter logic [WORD_W-1:0] HOLD_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_hit,
  input  logic [BIT_W-1:0]  set_bit,
  input  logic              clr_hit,
  input  logic [BIT_W-1:0]  clr_bit,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] sw_keep;
  logic [WORD_W-1:0] hw_keep;
  logic [WORD_W-1:0] set_vec;
  logic [WORD_W-1:0] nxt;

  generate
    if (POLICY == WR_CLEARS) begin : g_w1c
      assign sw_keep = wr_hit ? ~wr_data : '1;
    end else begin : g_ro
      logic unused_wr;
      assign unused_wr = wr_hit ^ (^wr_data);
      assign sw_keep   = '1;
    end
  endgenerate

  assign hw_keep = clr_hit ? ~(WORD_W'(1) << clr_bit) : '1;
  assign set_vec = set_hit ?  (WORD_W'(1) << set_bit) : '0;

  // Clears first, then the set, so a colliding set wins.
  always_comb begin
    nxt = ((q & sw_keep & hw_keep) | set_vec) & HOLD_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/evp_mask_bank.sv
module evp_mask_bank #(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WORDS-1:0]        wr_sel,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [NUM_WORDS*WORD_W-1:0] pend,
  output logic [NUM_WORDS*WORD_W-1:0] mask,
  output logic                        irq
);

  logic [WORD_W-1:0]    regs [NUM_WORDS];
  logic [NUM_WORDS-1:0] word_hit;

  generate
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_mask
      always_ff @(posedge clk) begin
        if (!rst_n)         regs[k] <= '0;
        else if (wr_sel[k]) regs[k] <= wr_data;
      end
      assign mask[k*WORD_W +: WORD_W] = regs[k];
      assign word_hit[k] = |(pend[k*WORD_W +: WORD_W] & regs[k]);
    end
  endgenerate

  assign irq = |word_hit;

endmodule

// File: rtl/evt_pend_ctrl.sv
module evt_pend_ctrl
  import evp_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int NUM_LVL   = 3,
  parameter int IDX_W     = 7,
  parameter int ADDR_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_set_valid,
  output logic               evt_set_ready,
  input  logic [IDX_W-1:0]   evt_set_idx,
  input  logic               evt_clr_valid,
  output logic               evt_clr_ready,
  input  logic [IDX_W-1:0]   evt_clr_idx,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic [NUM_LVL-1:0] irq
);

  localparam int BIT_W     = $clog2(WORD_W);
  localparam int SEL_W     = IDX_W - BIT_W;
  localparam int GRP_W     = ADDR_W - GRP_LSB;
  localparam int FLAT_W    = NUM_WORDS * WORD_W;
  localparam int CASC_BASE = WORD_W - NUM_WORDS;   // highest stored bit of word 0
  localparam logic [WORD_W-1:0] WORD0_HOLD =
    (WORD_W'(1) << (CASC_BASE + 1)) - WORD_W'(1);

  // ---------------- event streams ----------------
  logic             set_acc, clr_acc, set_ok, clr_ok;
  logic [SEL_W-1:0] set_word, clr_word;
  logic [BIT_W-1:0] set_bit, clr_bit;

  assign evt_set_ready = rst_n;
  assign evt_clr_ready = rst_n;
  assign set_acc  = evt_set_valid & evt_set_ready;
  assign clr_acc  = evt_clr_valid & evt_clr_ready;
  assign set_word = evt_set_idx[IDX_W-1:BIT_W];
  assign clr_word = evt_clr_idx[IDX_W-1:BIT_W];
  assign set_bit  = evt_set_idx[BIT_W-1:0];
  assign clr_bit  = evt_clr_idx[BIT_W-1:0];
  assign set_ok   = set_acc && ({1'b0, set_word} < (SEL_W+1)'(NUM_WORDS));
  assign clr_ok   = clr_acc && ({1'b0, clr_word} < (SEL_W+1)'(NUM_WORDS));

  // ---------------- register bus decode ----------------
  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;
  logic              slot_ok;
  logic              unused_lsb;

  assign grp        = reg_addr[ADDR_W-1:GRP_LSB];
  assign slot       = reg_addr[GRP_LSB-1:SLOT_LSB];
  assign slot_ok    = ({1'b0, slot} < (SLOT_W+1)'(NUM_WORDS));
  assign unused_lsb = ^reg_addr[SLOT_LSB-1:0];

  // ---------------- pending words ----------------
  logic [WORD_W-1:0] raw  [NUM_WORDS];
  logic [WORD_W-1:0] view [NUM_WORDS];
  logic [WORD_W-1:0] casc;
  logic [FLAT_W-1:0] pend_flat;

  generate
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
      localparam wr_policy_e        POL  = (k == 1) ? WR_IGNORED : WR_CLEARS;
      localparam logic [WORD_W-1:0] HOLD = (k == 0) ? WORD0_HOLD : '1;
      logic wr_hit;
      assign wr_hit = reg_wr_en && (grp == GRP_W'(GRP_PEND)) && (slot == SLOT_W'(k));

      evp_pend_word #(
        .WORD_W   (WORD_W),
        .BIT_W    (BIT_W),
        .POLICY   (POL),
        .HOLD_MASK(HOLD)
      ) u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_hit(set_ok && (set_word == SEL_W'(k))),
        .set_bit(set_bit),
        .clr_hit(clr_ok && (clr_word == SEL_W'(k))),
        .clr_bit(clr_bit),
        .wr_hit (wr_hit),
        .wr_data(reg_wdata),
        .q      (raw[k])
      );

      if (k == 0) begin : g_summary
        assign view[k] = raw[k] | casc;
      end else begin : g_plain
        assign view[k] = raw[k];
      end
      assign pend_flat[k*WORD_W +: WORD_W] = view[k];
    end
  endgenerate

  // Summary flags follow the registered upper words, so they move on the
  // same edge as the word they summarise (R2, R3, R6).
  always_comb begin
    casc = '0;
    for (int k = 1; k < NUM_WORDS; k++) casc[CASC_BASE + k] = |raw[k];
  end

  // ---------------- mask banks and interrupt levels ----------------
  logic [FLAT_W-1:0] mask_flat [NUM_LVL];

  generate
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      logic [NUM_WORDS-1:0] sel;
      always_comb begin
        for (int k = 0; k < NUM_WORDS; k++)
          sel[k] = reg_wr_en && (grp == GRP_W'(l + 1)) && (slot == SLOT_W'(k));
      end

      evp_mask_bank #(
        .NUM_WORDS(NUM_WORDS),
        .WORD_W   (WORD_W)
      ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (sel),
        .wr_data(reg_wdata),
        .pend   (pend_flat),
        .mask   (mask_flat[l]),
        .irq    (irq[l])
      );
    end
  endgenerate

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    if (slot_ok) begin
      if (grp == GRP_W'(GRP_PEND)) reg_rdata = pend_flat[int'(slot)*WORD_W +: WORD_W];
      for (int l = 0; l < NUM_LVL; l++)
        if (grp == GRP_W'(l + 1)) reg_rdata = mask_flat[l][int'(slot)*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/evp_checker.sv
module evp_checker #(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int NUM_LVL   = 3,
  parameter int IDX_W     = 7,
  parameter int ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        evt_set_valid,
  input logic [IDX_W-1:0]            evt_set_idx,
  input logic                        evt_clr_valid,
  input logic [IDX_W-1:0]            evt_clr_idx,
  input logic                        reg_wr_en,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [NUM_LVL-1:0]          irq,
  input logic [NUM_WORDS*WORD_W-1:0] pend_flat
);

  localparam int BIT_W     = $clog2(WORD_W);
  localparam int SEL_W     = IDX_W - BIT_W;
  localparam int CASC_BASE = WORD_W - NUM_WORDS;

  logic [SEL_W-1:0]  s_word, c_word;
  logic [BIT_W-1:0]  s_bit, c_bit;
  logic              s_in, s_out, c_in, collide;
  logic [WORD_W-1:0] word1;
  int                s_flat;

  assign s_word  = evt_set_idx[IDX_W-1:BIT_W];
  assign c_word  = evt_clr_idx[IDX_W-1:BIT_W];
  assign s_bit   = evt_set_idx[BIT_W-1:0];
  assign c_bit   = evt_clr_idx[BIT_W-1:0];
  assign s_in    = evt_set_valid && ({1'b0, s_word} < (SEL_W+1)'(NUM_WORDS));
  assign s_out   = evt_set_valid && !s_in;
  assign c_in    = evt_clr_valid && ({1'b0, c_word} < (SEL_W+1)'(NUM_WORDS));
  assign word1   = pend_flat[WORD_W +: WORD_W];
  assign s_flat  = int'(s_word) * WORD_W + int'(s_bit);
  assign collide = s_in && c_in && (evt_set_idx == evt_clr_idx) &&
                   ((s_word != '0) || (int'(s_bit) <= CASC_BASE));

  AST_SUM_LOW_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (s_in && s_word == SEL_W'(1)) |=> pend_flat[CASC_BASE + 1]);  // R2

  AST_SUM_HIGH_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (s_in && s_word == SEL_W'(2)) |=> pend_flat[CASC_BASE + 2]);  // R2

  AST_SUM_DROP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (c_in && !evt_set_valid && c_word == SEL_W'(1) && word1 == (WORD_W'(1) << c_bit))
    |=> !pend_flat[CASC_BASE + 1]);  // R3

  AST_SUM_NOT_SW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_W'(0) && word1 != '0 && !evt_clr_valid)
    |=> pend_flat[CASC_BASE + 1]);  // R4

  AST_WORD1_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_W'(4) &&
     !(s_in && s_word == SEL_W'(1)) && !(c_in && c_word == SEL_W'(1)))
    |=> $stable(word1));  // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> pend_flat[$past(s_flat)]);  // R8

  AST_OUT_OF_RANGE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_out && !evt_clr_valid && !reg_wr_en) |=> $stable(pend_flat));  // R9

  generate
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_irq_chk
      AST_IRQ_RISE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[l]) |-> $past(evt_set_valid || reg_wr_en));  // R7
    end
  endgenerate

endmodule

bind evt_pend_ctrl evp_checker #(
  .NUM_WORDS(NUM_WORDS),
  .WORD_W   (WORD_W),
  .NUM_LVL  (NUM_LVL),
  .IDX_W    (IDX_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_set_valid(evt_set_valid),
  .evt_set_idx  (evt_set_idx),
  .evt_clr_valid(evt_clr_valid),
  .evt_clr_idx  (evt_clr_idx),
  .reg_wr_en    (reg_wr_en),
  .reg_addr     (reg_addr),
  .irq          (irq),
  .pend_flat    (pend_flat)
);

// File: tb/evt_pend_ctrl_test.sv
`timescale 1ns/1ps
module evt_pend_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_set_valid = 1'b0, evt_clr_valid = 1'b0;
  logic        evt_set_ready, evt_clr_ready;
  logic [6:0]  evt_set_idx = '0, evt_clr_idx = '0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  // behavioural reference state
  bit [31:0] m_p [3];
  bit [31:0] m_m [3][3];

  always #2 clk = ~clk;   // 250 MHz

  evt_pend_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .evt_set_valid(evt_set_valid), .evt_set_ready(evt_set_ready), .evt_set_idx(evt_set_idx),
    .evt_clr_valid(evt_clr_valid), .evt_clr_ready(evt_clr_ready), .evt_clr_idx(evt_clr_idx),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic bit [31:0] m_word(int k);
    if (k == 0) return {m_p[2] != 0, m_p[1] != 0, m_p[0][29:0]};
    return m_p[k];
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    int g = a[7:4];
    int s = a[3:2];
    if (s > 2) return '0;
    if (g == 0) return m_word(s);
    if (g >= 1 && g <= 3) return m_m[g-1][s];
    return '0;
  endfunction

  function automatic bit [2:0] m_irq();
    bit [2:0] r = '0;
    for (int l = 0; l < 3; l++)
      for (int k = 0; k < 3; k++)
        if ((m_word(k) & m_m[l][k]) != 0) r[l] = 1'b1;
    return r;
  endfunction

  function automatic void m_step(bit sv, int si, bit cv, int ci, bit wv, bit [7:0] wa, bit [31:0] wd);
    int g = wa[7:4];
    int s = wa[3:2];
    if (wv && s <= 2) begin
      if (g == 0 && s == 0) m_p[0] &= ~(wd & 32'h3FFF_FFFF);
      if (g == 0 && s == 2) m_p[2] &= ~wd;
      if (g >= 1 && g <= 3) m_m[g-1][s] = wd;
    end
    if (cv && ci < 96) m_p[ci/32] &= ~(32'h1 << (ci % 32));
    if (sv && si < 96) m_p[si/32] |=  (32'h1 << (si % 32));
    m_p[0] &= 32'h3FFF_FFFF;
  endfunction

  task automatic check(bit ok, string req, string what, bit [31:0] act, bit [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock: drive, let the edge pass, compare against the model.
  task automatic cycle(bit sv, int si, bit cv, int ci, bit wv, bit [7:0] wa, bit [31:0] wd);
    evt_set_valid = sv; evt_set_idx = 7'(si);
    evt_clr_valid = cv; evt_clr_idx = 7'(ci);
    reg_wr_en = wv; reg_addr = wa; reg_wdata = wd;
    @(posedge clk);
    m_step(sv, si, cv, ci, wv, wa, wd);
    #1;
    check(evt_set_ready && evt_clr_ready, "R11", "ready", {30'd0, evt_set_ready, evt_clr_ready}, 32'h3);
    check(irq == m_irq(), "R7", "irq vs model", {29'd0, irq}, {29'd0, m_irq()});
    check(reg_rdata == m_read(wa), "R1", "rdata vs model", reg_rdata, m_read(wa));
    evt_set_valid = 0; evt_clr_valid = 0; reg_wr_en = 0;
  endtask

  task automatic expect_read(bit [7:0] a, bit [31:0] exp, string req);
    cycle(0, 0, 0, 0, 0, a, '0);
    check(reg_rdata == exp, req, "read", reg_rdata, exp);
  endtask

  task automatic expect_irq(bit [2:0] exp, string req);
    check(irq == exp, req, "irq", {29'd0, irq}, {29'd0, exp});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_p[i] = '0;
      for (int j = 0; j < 3; j++) m_m[i][j] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    check(!evt_set_ready && !evt_clr_ready, "R11", "ready in reset", {30'd0, evt_set_ready, evt_clr_ready}, 0);
    check(irq == 0, "R10", "irq in reset", {29'd0, irq}, 0);
    rst_n = 1'b1;

    // R10: reset contents
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 3; s++) expect_read(8'(g*16 + s*4), 32'h0, "R10");

    // R1 / R2: index mapping and summary flags
    cycle(1, 5, 0, 0, 0, 8'h00, 0);
    expect_read(8'h00, 32'h0000_0020, "R1");
    cycle(1, 40, 0, 0, 0, 8'h00, 0);
    expect_read(8'h04, 32'h0000_0100, "R1");
    expect_read(8'h00, 32'h4000_0020, "R2");
    cycle(1, 70, 0, 0, 0, 8'h00, 0);
    expect_read(8'h08, 32'h0000_0040, "R1");
    expect_read(8'h00, 32'hC000_0020, "R2");

    // R7: masks and levels
    cycle(0, 0, 0, 0, 1, 8'h10, 32'h0000_0020);
    expect_irq(3'b001, "R7");
    cycle(0, 0, 0, 0, 1, 8'h24, 32'h0000_0100);
    expect_irq(3'b011, "R7");
    cycle(0, 0, 0, 0, 1, 8'h30, 32'h8000_0000);
    expect_irq(3'b111, "R7");
    expect_read(8'h24, 32'h0000_0100, "R7");

    // R4: summary flags survive a write-all-ones
    cycle(0, 0, 0, 0, 1, 8'h00, 32'hFFFF_FFFF);
    expect_irq(3'b110, "R4");
    expect_read(8'h00, 32'hC000_0000, "R4");

    // R5: word 1 read-only
    cycle(0, 0, 0, 0, 1, 8'h04, 32'hFFFF_FFFF);
    expect_read(8'h04, 32'h0000_0100, "R5");

    // R3: hardware clears
    cycle(1, 41, 0, 0, 0, 8'h00, 0);
    cycle(0, 0, 1, 40, 0, 8'h00, 0);
    expect_read(8'h04, 32'h0000_0200, "R3");
    expect_read(8'h00, 32'hC000_0000, "R3");
    cycle(0, 0, 1, 41, 0, 8'h00, 0);
    expect_read(8'h04, 32'h0000_0000, "R3");
    expect_read(8'h00, 32'h8000_0000, "R3");
    expect_irq(3'b100, "R3");

    // R6: word 2 write-one-to-clear drops bit 31
    cycle(0, 0, 0, 0, 1, 8'h08, 32'h0000_0040);
    expect_read(8'h08, 32'h0, "R6");
    expect_read(8'h00, 32'h0, "R6");
    expect_irq(3'b000, "R6");

    // R8: collision
    cycle(1, 10, 1, 10, 0, 8'h00, 0);
    expect_read(8'h00, 32'h0000_0400, "R8");

    // R9: out-of-range numbers
    cycle(1, 100, 0, 0, 0, 8'h00, 0);
    cycle(0, 0, 1, 106, 0, 8'h00, 0);
    expect_read(8'h00, 32'h0000_0400, "R9");
    expect_read(8'h04, 32'h0, "R9");
    expect_read(8'h08, 32'h0, "R9");

    // R3: different bits set and cleared together
    cycle(1, 11, 1, 10, 0, 8'h00, 0);
    expect_read(8'h00, 32'h0000_0800, "R3");

    // R10: unmapped space
    cycle(0, 0, 0, 0, 1, 8'h0C, 32'hFFFF_FFFF);
    cycle(0, 0, 0, 0, 1, 8'h40, 32'hFFFF_FFFF);
    expect_read(8'h0C, 32'h0, "R10");
    expect_read(8'h40, 32'h0, "R10");
    expect_read(8'h00, 32'h0000_0800, "R10");

    // Mixed traffic against the model every cycle (R1..R9)
    for (int i = 0; i < 600; i++) begin
      bit [7:0] addrs [14] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h20,
                               8'h24, 8'h28, 8'h30, 8'h34, 8'h38, 8'h0C, 8'h40};
      int si = $urandom % 112;
      int ci = ($urandom % 4 == 0) ? si : ($urandom % 112);
      bit wv = ($urandom % 3 == 0);
      bit [31:0] wd = $urandom & $urandom;
      cycle($urandom % 2, si, $urandom % 2, ci, wv, addrs[$urandom % 14], wd);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule